// File: doc/BRIEF.md
# Passive-Serial FPGA Configuration Sequencer

This block loads a configuration bitstream into one of several FPGAs over a passive-serial link. Each target FPGA has its own active-low select line. The sequencer drives only the chosen device's line low, so targets can be loaded in any order. The completion of each load is judged from that target's own done line.

A load begins with a start pulse and a target index. The sequencer holds the shared configuration-reset line low for a fixed time and waits for the target's status line to rise. From that moment it shifts bitstream bits out on a serial clock and data pin. The bytes come from an external flash reader through a request/valid handshake. The sequencer stops clocking when the target raises done. It then waits for the init-done indication before it reports success. A status drop during shifting, a stuck done line, a bad index or a stalled load ends the sequence with an error.

Top module: `ps_cfg_seq`

## Requirements
- R1: While busy, exactly one bit of `sel_n_o` is low: the one at the index latched at start. While idle, all bits of `sel_n_o` are high.
- R2: After a start is accepted, `cfg_n_o` is held low for exactly 40*CLK_MHZ clock cycles and then returns high.
- R3: Shifting begins on the first low-to-high transition of the target's `stat_i` after the reset pulse. If the target's `cdone_i` is still high at that transition, the load ends with an error and no serial clock edge.
- R4: Bits are sent least-significant bit first, eight per byte. Each byte comes from one cycle where `byte_req_o` and `byte_vld_i` are both high. `byte_req_o` stays high until `byte_vld_i` arrives.
- R5: `sdat_o` changes only while `sclk_o` is low, so it is stable at every rising edge of `sclk_o`. `sclk_o` is low whenever the sequencer is not shifting.
- R6: When the target's `cdone_i` rises, shifting stops and `sclk_o` stays low for the rest of the sequence.
- R7: `done_o` rises at least 18*CLK_MHZ cycles after `cdone_i` is seen high. It also requires that the target's `idone_i` has been low at some point and is now high.
- R8: If the target's `stat_i` goes low during shifting, the sequencer raises `err_o`, returns to idle and releases every select line.
- R9: If a load is not complete within TMO_CYC cycles of the end of the reset pulse, the sequencer raises `err_o` and returns to idle.
- R10: A start is taken only when idle. A start pulse while busy does not change the target being loaded.
- R11: A start with an index of N_TGT or more sets `err_o` at once. It does not pulse `cfg_n_o` and does not become busy.
- R12: After reset, `busy_o`, `done_o` and `err_o` are low. `done_o` and `err_o` hold their value until the next accepted start clears them, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load (one-cycle pulse) |
| tgt_i | input | IDX_W | Target index sampled with start_i |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last load completed |
| err_o | output | 1 | Last load failed |
| byte_req_o | output | 1 | Next bitstream byte wanted |
| byte_vld_i | input | 1 | byte_i holds the requested byte |
| byte_i | input | 8 | Bitstream byte |
| sel_n_o | output | N_TGT | Per-target active-low select |
| cfg_n_o | output | 1 | Active-low configuration reset, shared |
| stat_i | input | N_TGT | Per-target status lines |
| cdone_i | input | N_TGT | Per-target configuration-done lines |
| idone_i | input | N_TGT | Per-target init-done lines |
| sclk_o | output | 1 | Serial configuration clock |
| sdat_o | output | 1 | Serial configuration data |

## Verification
Several properties are checked by assertions on every cycle. These are the single-select rule, the exact reset-pulse length, data stability at each serial clock rise, the silent clock after done, and the exclusive and idle-returning status flags. Other behaviours can only be shown by the bench scenarios against a model target. These are the bit order and content of the stream, the 18-microsecond wait before done, the errors for a status drop, a stuck done line, a watchdog expiry or a bad index, the freedom to load targets in any order, and a start ignored while busy.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_WSTAT,
    ST_SHIFT,
    ST_WINIT
  } psc_state_e;
endpackage

// File: rtl/psc_sync.sv
module psc_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/psc_shift.sv
module psc_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  output logic       byte_req_o,
  output logic       sclk_o,
  output logic       sdat_o
);
  logic       have_q, sclk_q, sdat_q;
  logic [7:0] sh_q;
  logic [2:0] left_q;

  assign byte_req_o = en_i && !have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      sclk_q <= 1'b0;
      sdat_q <= 1'b0;
      sh_q   <= '0;
      left_q <= '0;
    end else if (!en_i) begin
      have_q <= 1'b0;
      sclk_q <= 1'b0;
      sdat_q <= 1'b0;
    end else if (!have_q) begin
      if (byte_vld_i) begin
        sh_q   <= byte_i;
        sdat_q <= byte_i[0];
        left_q <= 3'd7;
        have_q <= 1'b1;
      end
    end else if (!sclk_q) begin
      sclk_q <= 1'b1;
    end else begin
      // falling edge: advance data while clock is low
      sclk_q <= 1'b0;
      if (left_q == 3'd0) begin
        have_q <= 1'b0;
      end else begin
        sh_q   <= sh_q >> 1;
        sdat_q <= sh_q[1];
        left_q <= left_q - 3'd1;
      end
    end
  end

  assign sclk_o = sclk_q;
  assign sdat_o = sdat_q;

  a_r5_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |-> $stable(sdat_q));
  a_r5_clk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !sclk_q);
endmodule

// File: rtl/ps_cfg_seq.sv
module ps_cfg_seq
  import psc_pkg::*;
#(
  parameter int unsigned N_TGT   = 3,
  parameter int unsigned CLK_MHZ = 100,
  parameter int unsigned TMO_CYC = 2_000_000,
  localparam int unsigned IDX_W  = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] tgt_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             byte_req_o,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  output logic [N_TGT-1:0] sel_n_o,
  output logic             cfg_n_o,
  input  logic [N_TGT-1:0] stat_i,
  input  logic [N_TGT-1:0] cdone_i,
  input  logic [N_TGT-1:0] idone_i,
  output logic             sclk_o,
  output logic             sdat_o
);
  localparam int unsigned RST_CYC  = 40 * CLK_MHZ;
  localparam int unsigned INIT_CYC = 18 * CLK_MHZ;

  psc_state_e       state_q;
  logic [IDX_W-1:0] sel_q;
  logic [31:0]      tmr_q, wd_q;
  logic             done_q, err_q, seen_low_q, st_prev_q;
  logic [N_TGT-1:0] st_s, cd_s, id_s;
  logic             st_m, cd_m, id_m, shift_en;

  psc_sync #(.W(3 * N_TGT)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({idone_i, cdone_i, stat_i}),
    .q_o    ({id_s, cd_s, st_s})
  );

  always_comb begin
    st_m = 1'b1;
    cd_m = 1'b0;
    id_m = 1'b1;
    for (int i = 0; i < int'(N_TGT); i++) begin
      if (sel_q == IDX_W'(i)) begin
        st_m = st_s[i];
        cd_m = cd_s[i];
        id_m = id_s[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      sel_q      <= '0;
      tmr_q      <= '0;
      wd_q       <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      seen_low_q <= 1'b0;
      st_prev_q  <= 1'b1;
    end else begin
      st_prev_q <= st_m;
      if (state_q != ST_IDLE && !id_m) seen_low_q <= 1'b1;
      if (state_q inside {ST_WSTAT, ST_SHIFT, ST_WINIT}) wd_q <= wd_q + 32'd1;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          done_q <= 1'b0;
          err_q  <= 1'b0;
          if (32'(tgt_i) < N_TGT) begin
            sel_q      <= tgt_i;
            tmr_q      <= '0;
            seen_low_q <= 1'b0;
            state_q    <= ST_RST;
          end else begin
            err_q <= 1'b1;
          end
        end
        ST_RST: begin
          if (tmr_q == RST_CYC - 1) begin
            wd_q    <= '0;
            state_q <= ST_WSTAT;
          end else begin
            tmr_q <= tmr_q + 32'd1;
          end
        end
        default: begin
          if (wd_q == TMO_CYC - 1) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (state_q == ST_WSTAT) begin
            if (!st_prev_q && st_m) begin
              if (cd_m) begin
                err_q   <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                state_q <= ST_SHIFT;
              end
            end
          end else if (state_q == ST_SHIFT) begin
            if (!st_m) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else if (cd_m) begin
              tmr_q   <= '0;
              state_q <= ST_WINIT;
            end
          end else begin
            if (tmr_q < INIT_CYC - 1) tmr_q <= tmr_q + 32'd1;
            else if (seen_low_q && id_m) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  // drop the clock in the same edge that sees done or a status fault
  assign shift_en = (state_q == ST_SHIFT) && st_m && !cd_m;

  psc_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (shift_en),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .byte_req_o (byte_req_o),
    .sclk_o     (sclk_o),
    .sdat_o     (sdat_o)
  );

  for (genvar g = 0; g < int'(N_TGT); g++) begin : g_sel
    assign sel_n_o[g] = !((state_q != ST_IDLE) && (sel_q == IDX_W'(g)));
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign cfg_n_o = (state_q != ST_RST);

  a_r1_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($countones(~sel_n_o) == 1));
  a_r1_idle_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sel_n_o == '1));
  a_r2_reset_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_n_o) |-> ($past(tmr_q) == RST_CYC - 1));
  a_r6_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WINIT) |-> !sclk_o);
  a_r12_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  a_r8_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o);
endmodule

// File: tb/ps_cfg_seq_test.sv
module ps_cfg_seq_test;
  localparam int NT = 3;
  localparam int MHZ = 1;
  localparam int TMO = 3000;
  localparam int RSTC = 40 * MHZ;
  localparam int INITC = 18 * MHZ;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, byte_vld_i = 1'b0;
  logic [1:0] tgt_i = '0;
  logic [7:0] byte_i = '0;
  logic [NT-1:0] stat_i = '1, cdone_i = '1, idone_i = '1;
  logic busy_o, done_o, err_o, byte_req_o, cfg_n_o, sclk_o, sdat_o;
  logic [NT-1:0] sel_n_o;

  ps_cfg_seq #(.N_TGT(NT), .CLK_MHZ(MHZ), .TMO_CYC(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .tgt_i(tgt_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .byte_req_o(byte_req_o), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .sel_n_o(sel_n_o), .cfg_n_o(cfg_n_o), .stat_i(stat_i),
    .cdone_i(cdone_i), .idone_i(idone_i), .sclk_o(sclk_o), .sdat_o(sdat_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, rx_n = 0, ptr = 0;
  logic [7:0] mem [64];
  logic [1023:0] rx_bits;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge sclk_o) begin
    if (rx_n < 1024) rx_bits[rx_n] = sdat_o;
    rx_n = rx_n + 1;
  end

  // flash reader model: answers each request two cycles later
  always begin
    @(negedge clk);
    if (byte_req_o) begin
      repeat (2) @(negedge clk);
      byte_vld_i = 1'b1;
      byte_i = mem[ptr % 64];
      ptr = ptr + 1;
      @(negedge clk);
      byte_vld_i = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mode: 0 normal, 1 status drop, 2 done never rises, 3 done stuck high
  task automatic run_load(input int tgt, input int nbytes, input int mode, input bit poke);
    int w, low, loops, since, late, t_cd, bad_bits;
    bit sel_ok, cd, poked;
    logic [NT-1:0] exp_sel;
    exp_sel = ~(NT'(1) << tgt);
    for (int i = 0; i < 64; i++) mem[i] = 8'((i * 37 + tgt * 91 + 5) & 255);
    ptr = 0; rx_n = 0; cd = 0; since = 0; late = 0; t_cd = 0; poked = 0;
    @(negedge clk); start_i = 1'b1; tgt_i = 2'(tgt);
    @(negedge clk); start_i = 1'b0;
    chk(busy_o && !done_o && !err_o, "R12 start clears flags", {busy_o, done_o, err_o}, 3'b100);
    w = 0;
    while (cfg_n_o && w < 100) begin @(negedge clk); w++; end
    stat_i[tgt] = 1'b0;
    if (mode != 3) cdone_i[tgt] = 1'b0;
    low = 0; sel_ok = 1;
    while (!cfg_n_o && low < 1000) begin
      if (sel_n_o != exp_sel) sel_ok = 0;
      low++;
      @(negedge clk);
    end
    chk(low == RSTC, "R2 reset pulse length", low, RSTC);
    chk(sel_ok, "R1 only selected target enabled", sel_n_o, exp_sel);
    repeat (3) @(negedge clk);
    stat_i[tgt] = 1'b1;
    loops = 0;
    while (busy_o && loops < 20000) begin
      @(negedge clk);
      loops++;
      if (poke && !poked && rx_n >= 8) begin
        poked = 1;
        start_i = 1'b1; tgt_i = 2'((tgt + 1) % NT);
        @(negedge clk);
        start_i = 1'b0;
        chk(sel_n_o == exp_sel, "R10 start while busy ignored", sel_n_o, exp_sel);
      end
      if (mode == 0 && !cd && rx_n >= nbytes * 8) begin
        cdone_i[tgt] = 1'b1; cd = 1; t_cd = cyc;
      end
      if (mode == 1 && rx_n >= 5) stat_i[tgt] = 1'b0;
      if (cd) begin
        since++;
        if (since == 2) idone_i[tgt] = 1'b0;
        if (since == 7) idone_i[tgt] = 1'b1;
        if (since >= 4 && sclk_o) late++;
      end
    end
    case (mode)
      0: begin
        bad_bits = 0;
        for (int b = 0; b < nbytes * 8; b++)
          if (rx_bits[b] !== mem[b / 8][b % 8]) bad_bits++;
        chk(bad_bits == 0, "R4 stream content lsb first", bad_bits, 0);
        chk(done_o && !err_o, "R7 done reported", {done_o, err_o}, 2'b10);
        chk(cyc - t_cd >= INITC, "R7 init wait", cyc - t_cd, INITC);
        chk(late == 0, "R6 clock stops after done", late, 0);
        chk(rx_n <= nbytes * 8 + 3, "R6 few edges past done", rx_n, nbytes * 8);
      end
      1: begin
        chk(err_o && !done_o, "R8 status drop error", {done_o, err_o}, 2'b01);
        chk(sel_n_o == '1, "R8 selects released", sel_n_o, 7);
      end
      2: begin
        chk(err_o, "R9 watchdog error", err_o, 1);
        chk(loops >= TMO - 10 && loops <= TMO + 10, "R9 watchdog time", loops, TMO);
      end
      default: begin
        chk(err_o, "R3 stuck done error", err_o, 1);
        chk(rx_n == 0, "R3 no clock when done stuck", rx_n, 0);
      end
    endcase
    stat_i = '1; cdone_i = '1; idone_i = '1;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset;
    chk(!busy_o && !done_o && !err_o, "R12 reset flags", {busy_o, done_o, err_o}, 0);
    chk(sel_n_o == '1 && cfg_n_o, "R1 reset selects high", sel_n_o, 7);
    chk(!sclk_o && !byte_req_o, "R5 clock idle at reset", sclk_o, 0);
  endtask

  task automatic test_bad_index;
    bit pulsed;
    pulsed = 0;
    @(negedge clk); start_i = 1'b1; tgt_i = 2'd3;
    @(negedge clk); start_i = 1'b0;
    chk(err_o && !busy_o, "R11 bad index error", {busy_o, err_o}, 2'b01);
    for (int i = 0; i < 50; i++) begin
      if (!cfg_n_o || busy_o) pulsed = 1;
      @(negedge clk);
    end
    chk(!pulsed, "R11 no reset pulse", pulsed, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    test_reset();
    run_load(1, 3, 0, 0);
    run_load(2, 2, 0, 0);
    run_load(0, 4, 0, 1);
    run_load(2, 3, 1, 0);
    run_load(0, 2, 3, 0);
    test_bad_index();
    run_load(1, 2, 0, 0);
    run_load(1, 2, 2, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule